// File: doc/BRIEF.md
# Sliding-Window Codeword Input Cache

This block sits between an external codeword store and a sliding-window max-log-MAP soft-in/soft-out decoder. The decoder splits the codeword into sub-blocks of `SUB_LEN` trellis steps. In each window period three metric engines each read one of three consecutive sub-blocks. The forward engine reads the middle sub-block. The dummy-backward engine reads the newest complete sub-block. The true-backward engine reads the oldest sub-block. The block accepts one codeword word per datapath cycle and returns three words per datapath cycle. One word holds the systematic soft value (upper `SYM_W` bits) and the parity soft value (lower `SYM_W` bits) of one trellis step, both signed.

Storage is three banks of `SUB_LEN` words. The bank being refilled is the bank the true-backward engine drains. The refill walks the bank in ascending logical order while the true-backward read walks it in descending order. Each write lands in the physical slot that was read one fast-clock slot earlier. To keep logical addressing stable, each bank carries an orientation bit that flips every time the bank is refilled. A dual-port array clocked at twice the datapath rate (`clk2x`) gives four accesses per datapath cycle. Port A reads for the forward and then the dummy-backward engine. Port B reads for the true-backward engine and then performs the write.

The slot sequencer has two states. `SLOT_FWD_TBK` covers the forward and true-backward reads. `SLOT_DBK_WR` covers the dummy-backward read and the write. The transition `FWD_TBK->DBK_WR` is taken on every edge in `SLOT_FWD_TBK`. The transition `DBK_WR->FWD_TBK` is taken on every edge in `SLOT_DBK_WR`. Reset enters `SLOT_FWD_TBK`. One datapath cycle is one `SLOT_FWD_TBK` edge followed by one `SLOT_DBK_WR` edge. All inputs are held for the whole datapath cycle.

Top module: `swc_cache_top`

## Requirements
- R1: After reset the three output words are zero and the first `clk2x` edge after reset release is a `SLOT_FWD_TBK` edge.
- R2: The sequencer alternates `SLOT_FWD_TBK` and `SLOT_DBK_WR` on every edge. The output words change only on `SLOT_FWD_TBK` edges and hold across `SLOT_DBK_WR` edges.
- R3: Read addresses presented during datapath cycle n produce their words on the outputs for the whole of datapath cycle n+1.
- R4: With bank pointer p (0 after reset), bank p is the true-backward and refill bank, bank (p+1) mod 3 is the forward bank and bank (p+2) mod 3 is the dummy-backward bank. `win_step` advances p modulo 3. A sub-block written in period t is read by the dummy-backward engine in t+1, by the forward engine in t+2 and by the true-backward engine in t+3. Total storage is 3×`SUB_LEN` words.
- R5: Each datapath cycle with `wr_en` high stores `wr_word` as the next ascending logical offset (starting at 0) of the refill bank. A cycle with `wr_en` low stores nothing and leaves the write count unchanged, whatever `wr_word` carries.
- R6: The user drives `tbk_addr` to `SUB_LEN-1-k`, where k is the number of words written in the current period. The true-backward read is served before the write in the same datapath cycle, so it returns the old sub-block's symbol.
- R7: Forward and dummy-backward reads at any logical offset return the symbol written at that offset, whichever orientation the bank was filled in.
- R8: `win_start` clears the bank pointer, the write count and all orientation bits, and it takes priority over a simultaneous `win_step`.
- R9: A `win_step` in the same datapath cycle as a write stores that word in the old refill bank first and then advances the pointer and clears the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Array clock at twice the datapath rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_start | input | 1 | Start of a new code block |
| win_step | input | 1 | Window boundary: rotate bank roles |
| wr_en | input | 1 | Incoming codeword word valid this datapath cycle |
| wr_word | input | 2*SYM_W | Systematic (high) and parity (low) soft values |
| fwd_addr | input | clog2(SUB_LEN) | Forward engine logical offset |
| dbk_addr | input | clog2(SUB_LEN) | Dummy-backward engine logical offset |
| tbk_addr | input | clog2(SUB_LEN) | True-backward engine logical offset |
| fwd_word | output | 2*SYM_W | Forward engine read word |
| dbk_word | output | 2*SYM_W | Dummy-backward engine read word |
| tbk_word | output | 2*SYM_W | True-backward engine read word |

## Verification
The bench builds the block with its defaults: `SUB_LEN` of 20 and 4-bit symbols, giving a 60-word array. Twenty-step sub-blocks let ten periods wrap the bank pointer three times. Over that run every bank is refilled in both orientations, so reads through a flipped bank are reached alongside the first-offset and last-offset corners. Idle write cycles with junk data, a window step in the cycle that carries a write, and a mid-stream restart with a simultaneous step all fall inside the same short stream.

// File: rtl/swc_pkg.sv
package swc_pkg;
    typedef enum logic {
        SLOT_FWD_TBK = 1'b0,
        SLOT_DBK_WR  = 1'b1
    } slot_e;

    localparam int NUM_BANKS = 3;
endpackage

// File: rtl/swc_slot_seq.sv
module swc_slot_seq
    import swc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output slot_e slot
);
    slot_e slot_q;
    slot_e slot_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= SLOT_FWD_TBK;
        else        slot_q <= slot_nxt;
    end

    always_comb begin
        slot_nxt = SLOT_FWD_TBK;
        unique case (slot_q)
            SLOT_FWD_TBK: slot_nxt = SLOT_DBK_WR;
            SLOT_DBK_WR:  slot_nxt = SLOT_FWD_TBK;
        endcase
    end

    assign slot = slot_q;
endmodule

// File: rtl/swc_bank_map.sv
module swc_bank_map
    import swc_pkg::*;
#(
    parameter int SUB_LEN = 20,
    parameter int OW      = $clog2(SUB_LEN),
    parameter int AW      = $clog2(NUM_BANKS * SUB_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          upd,
    input  logic          win_start,
    input  logic          win_step,
    input  logic          wr_en,
    input  logic [OW-1:0] fwd_off,
    input  logic [OW-1:0] dbk_off,
    input  logic [OW-1:0] tbk_off,
    output logic [AW-1:0] fwd_loc,
    output logic [AW-1:0] dbk_loc,
    output logic [AW-1:0] tbk_loc,
    output logic [AW-1:0] wr_loc,
    output logic [OW-1:0] wr_cnt,
    output logic [1:0]    bank_ptr
);
    localparam logic [OW-1:0] CNT_LAST = OW'(SUB_LEN - 1);
    localparam logic [AW-1:0] OFF_LAST = AW'(SUB_LEN - 1);
    localparam logic [AW-1:0] BANK_SZ  = AW'(SUB_LEN);

    logic [NUM_BANKS-1:0] orient;
    logic [1:0]           role_bank [NUM_BANKS];
    logic [OW-1:0]        role_off  [NUM_BANKS];
    logic [AW-1:0]        role_loc  [NUM_BANKS];

    // R4: role 0 true-backward/refill, role 1 forward, role 2 dummy-backward
    assign role_bank[0] = bank_ptr;
    assign role_bank[1] = (bank_ptr == 2'd2) ? 2'd0 : bank_ptr + 2'd1;
    assign role_bank[2] = (bank_ptr == 2'd0) ? 2'd2 : bank_ptr - 2'd1;
    assign role_off[0]  = tbk_off;
    assign role_off[1]  = fwd_off;
    assign role_off[2]  = dbk_off;

    // R7: logical offset to physical slot through the bank orientation bit
    for (genvar r = 0; r < NUM_BANKS; r++) begin : g_xlate
        logic [AW-1:0] off_w;
        assign off_w       = AW'(role_off[r]);
        assign role_loc[r] = AW'(role_bank[r]) * BANK_SZ
                           + (orient[role_bank[r]] ? OFF_LAST - off_w : off_w);
    end

    assign tbk_loc = role_loc[0];
    assign fwd_loc = role_loc[1];
    assign dbk_loc = role_loc[2];

    // R6: the write lands where the true-backward read of offset SUB_LEN-1-cnt went
    assign wr_loc = AW'(bank_ptr) * BANK_SZ
                  + (orient[bank_ptr] ? AW'(wr_cnt) : OFF_LAST - AW'(wr_cnt));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_ptr <= 2'd0;
            wr_cnt   <= '0;
            orient   <= '0;
        end else if (upd) begin
            if (win_start) begin
                bank_ptr <= 2'd0;
                wr_cnt   <= '0;
                orient   <= '0;
            end else if (win_step) begin
                bank_ptr         <= role_bank[1];
                wr_cnt           <= '0;
                orient[bank_ptr] <= ~orient[bank_ptr];
            end else if (wr_en && wr_cnt != CNT_LAST) begin
                wr_cnt <= wr_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/swc_dp_array.sv
module swc_dp_array #(
    parameter int WORD_W = 8,
    parameter int DEPTH  = 60,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     a_addr,
    output logic [WORD_W-1:0] a_q,
    input  logic [AW-1:0]     b_addr,
    input  logic              b_we,
    input  logic [WORD_W-1:0] b_wd,
    output logic [WORD_W-1:0] b_q
);
    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (b_we) mem[b_addr] <= b_wd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= mem[a_addr];
            if (!b_we) b_q <= mem[b_addr];
        end
    end
endmodule

// File: rtl/swc_cache_top.sv
module swc_cache_top
    import swc_pkg::*;
#(
    parameter int SUB_LEN  = 20,
    parameter int SYM_W    = 4,
    localparam int OW      = $clog2(SUB_LEN),
    localparam int WORD_W  = 2 * SYM_W
) (
    input  logic              clk2x,
    input  logic              rst_n,
    input  logic              win_start,
    input  logic              win_step,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    input  logic [OW-1:0]     fwd_addr,
    input  logic [OW-1:0]     dbk_addr,
    input  logic [OW-1:0]     tbk_addr,
    output logic [WORD_W-1:0] fwd_word,
    output logic [WORD_W-1:0] dbk_word,
    output logic [WORD_W-1:0] tbk_word
);
    // R4: three banks only, 3*SUB_LEN words in total
    localparam int DEPTH = NUM_BANKS * SUB_LEN;
    localparam int AW    = $clog2(DEPTH);

    slot_e             slot;
    logic [AW-1:0]     fwd_loc, dbk_loc, tbk_loc, wr_loc;
    logic [AW-1:0]     a_addr, b_addr;
    logic              b_we;
    logic [WORD_W-1:0] a_q, b_q;
    logic [WORD_W-1:0] fwd_hold, tbk_hold;
    logic [OW-1:0]     wr_cnt;
    logic [1:0]        bank_ptr;

    swc_slot_seq u_seq (
        .clk   (clk2x),
        .rst_n (rst_n),
        .slot  (slot)
    );

    swc_bank_map #(.SUB_LEN(SUB_LEN), .OW(OW), .AW(AW)) u_map (
        .clk       (clk2x),
        .rst_n     (rst_n),
        .upd       (slot == SLOT_DBK_WR),
        .win_start (win_start),
        .win_step  (win_step),
        .wr_en     (wr_en),
        .fwd_off   (fwd_addr),
        .dbk_off   (dbk_addr),
        .tbk_off   (tbk_addr),
        .fwd_loc   (fwd_loc),
        .dbk_loc   (dbk_loc),
        .tbk_loc   (tbk_loc),
        .wr_loc    (wr_loc),
        .wr_cnt    (wr_cnt),
        .bank_ptr  (bank_ptr)
    );

    // R2: port A serves forward then dummy-backward, port B true-backward then write
    always_comb begin
        a_addr = fwd_loc;
        b_addr = tbk_loc;
        b_we   = 1'b0;
        unique case (slot)
            SLOT_FWD_TBK: begin
                a_addr = fwd_loc;
                b_addr = tbk_loc;
            end
            SLOT_DBK_WR: begin
                a_addr = dbk_loc;
                b_addr = wr_loc;
                b_we   = wr_en;
            end
        endcase
    end

    swc_dp_array #(.WORD_W(WORD_W), .DEPTH(DEPTH), .AW(AW)) u_array (
        .clk    (clk2x),
        .rst_n  (rst_n),
        .a_addr (a_addr),
        .a_q    (a_q),
        .b_addr (b_addr),
        .b_we   (b_we),
        .b_wd   (wr_word),
        .b_q    (b_q)
    );

    // R3: all three words appear together one datapath cycle after their addresses
    always_ff @(posedge clk2x or negedge rst_n) begin
        if (!rst_n) begin
            fwd_hold <= '0;
            tbk_hold <= '0;
            fwd_word <= '0;
            dbk_word <= '0;
            tbk_word <= '0;
        end else begin
            unique case (slot)
                SLOT_FWD_TBK: begin
                    fwd_word <= fwd_hold;
                    dbk_word <= a_q;
                    tbk_word <= tbk_hold;
                end
                SLOT_DBK_WR: begin
                    fwd_hold <= a_q;
                    tbk_hold <= b_q;
                end
            endcase
        end
    end
endmodule

// File: rtl/swc_cache_chk.sv
module swc_cache_chk
    import swc_pkg::*;
#(
    parameter int SUB_LEN = 20,
    parameter int SYM_W   = 4,
    parameter int OW      = $clog2(SUB_LEN),
    parameter int AW      = $clog2(NUM_BANKS * SUB_LEN),
    parameter int WORD_W  = 2 * SYM_W
) (
    input logic              clk,
    input logic              rst_n,
    input slot_e             slot,
    input logic              b_we,
    input logic [AW-1:0]     b_addr,
    input logic [OW-1:0]     wr_cnt,
    input logic [1:0]        bank_ptr,
    input logic              win_start,
    input logic              win_step,
    input logic [WORD_W-1:0] fwd_word,
    input logic [WORD_W-1:0] dbk_word,
    input logic [WORD_W-1:0] tbk_word
);
    // R2
    slot_fwd_to_dbk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_FWD_TBK) |=> (slot == SLOT_DBK_WR));

    // R2
    slot_dbk_to_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_DBK_WR) |=> (slot == SLOT_FWD_TBK));

    // R2
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_DBK_WR) |=> ($stable(fwd_word) && $stable(dbk_word) && $stable(tbk_word)));

    // R6
    war_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b_we |-> (b_addr == $past(b_addr)));

    // R5
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt <= OW'(SUB_LEN - 1));

    // R4
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bank_ptr != 2'd3);

    // R4
    ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_DBK_WR && win_step && !win_start) |=>
        (bank_ptr == (($past(bank_ptr) == 2'd2) ? 2'd0 : $past(bank_ptr) + 2'd1)));

    // R8
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slot == SLOT_DBK_WR && win_start) |=> (bank_ptr == 2'd0 && wr_cnt == '0));
endmodule

bind swc_cache_top swc_cache_chk #(.SUB_LEN(SUB_LEN), .SYM_W(SYM_W)) u_chk (
    .clk       (clk2x),
    .rst_n     (rst_n),
    .slot      (slot),
    .b_we      (b_we),
    .b_addr    (b_addr),
    .wr_cnt    (wr_cnt),
    .bank_ptr  (bank_ptr),
    .win_start (win_start),
    .win_step  (win_step),
    .fwd_word  (fwd_word),
    .dbk_word  (dbk_word),
    .tbk_word  (tbk_word)
);

// File: tb/swc_cache_top_bench.sv
module swc_cache_top_bench;
    localparam int CLK_P   = 10;
    localparam int SUB_LEN = 20;
    localparam int NSUB    = 16;

    logic       clk2x = 1'b0;
    logic       rst_n = 1'b0;
    logic       win_start = 1'b0, win_step = 1'b0, wr_en = 1'b0;
    logic [7:0] wr_word = '0;
    logic [4:0] fwd_addr = '0, dbk_addr = '0, tbk_addr = '0;
    logic [7:0] fwd_word, dbk_word, tbk_word;

    int checks = 0;
    int fails  = 0;

    logic [7:0] sym [NSUB][SUB_LEN];

    bit         vf, vd, vt, nvf, nvd, nvt;
    logic [7:0] ef, ed, et, nef, ned, net;
    string      tf, td, tt, ntf, ntd, ntt;

    always #(CLK_P/2) clk2x = ~clk2x;

    swc_cache_top u_swc_cache_top (
        .clk2x(clk2x), .rst_n(rst_n), .win_start(win_start), .win_step(win_step),
        .wr_en(wr_en), .wr_word(wr_word), .fwd_addr(fwd_addr), .dbk_addr(dbk_addr),
        .tbk_addr(tbk_addr), .fwd_word(fwd_word), .dbk_word(dbk_word), .tbk_word(tbk_word)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // one datapath cycle: inputs already driven at a negedge ahead of a read-slot edge
    task automatic step_dp();
        logic [7:0] sf, sd, st;
        @(posedge clk2x); @(negedge clk2x);
        if (vf) chk(tf, fwd_word, ef);
        if (vd) chk(td, dbk_word, ed);
        if (vt) chk(tt, tbk_word, et);
        sf = fwd_word; sd = dbk_word; st = tbk_word;
        @(posedge clk2x); @(negedge clk2x);
        chk("R2 fwd hold", fwd_word, sf);
        chk("R2 dbk hold", dbk_word, sd);
        chk("R2 tbk hold", tbk_word, st);
        vf = nvf; vd = nvd; vt = nvt;
        ef = nef; ed = ned; et = net;
        tf = ntf; td = ntd; tt = ntt;
    endtask

    task automatic run_period(input int base, input int t);
        int i = 0;
        while (i < SUB_LEN) begin
            bit idle = ($urandom_range(0, 4) == 0);
            int fa = (i == 0) ? 0 : (i == SUB_LEN-1) ? SUB_LEN-1 : int'($urandom_range(0, SUB_LEN-1));
            int da = (i == 0) ? SUB_LEN-1 : (i == SUB_LEN-1) ? 0 : int'($urandom_range(0, SUB_LEN-1));
            win_start = 1'b0;
            win_step  = !idle && (i == SUB_LEN-1);
            wr_en     = !idle;
            wr_word   = idle ? ~sym[base+t][i] : sym[base+t][i];
            fwd_addr  = 5'(fa);
            dbk_addr  = 5'(da);
            tbk_addr  = 5'(SUB_LEN-1-i);
            nvf = (t >= 2); nvd = (t >= 1); nvt = (t >= 3);
            nef = (t >= 2) ? sym[base+t-2][fa] : '0;
            ned = (t >= 1) ? sym[base+t-1][da] : '0;
            net = (t >= 3) ? sym[base+t-3][SUB_LEN-1-i] : '0;
            ntf = (base != 0) ? "R3 R4 R7 R8 fwd" : "R3 R4 R7 fwd";
            ntd = (base != 0) ? "R4 R7 R8 dbk" : "R4 R7 dbk";
            ntt = idle ? "R5 R6 tbk idle" : "R6 R9 tbk";
            step_dp();
            if (!idle) i++;
        end
    endtask

    initial begin
        #(CLK_P * 50000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd11));
        for (int s = 0; s < NSUB; s++)
            for (int k = 0; k < SUB_LEN; k++)
                sym[s][k] = 8'($urandom);
        vf = 1; vd = 1; vt = 1; ef = '0; ed = '0; et = '0;
        tf = "R1 fwd reset"; td = "R1 dbk reset"; tt = "R1 tbk reset";
        repeat (3) @(negedge clk2x);
        rst_n = 1'b1;
        for (int t = 0; t < 10; t++) run_period(0, t);
        // R8: restart with a simultaneous step, start must win
        win_start = 1'b1; win_step = 1'b1; wr_en = 1'b0;
        nvf = 0; nvd = 0; nvt = 0;
        step_dp();
        for (int t = 0; t < 6; t++) run_period(10, t);
        win_start = 1'b0; win_step = 1'b0; wr_en = 1'b0;
        nvf = 0; nvd = 0; nvt = 0;
        step_dp();
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule